// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This unit finds the single operand of an accumulator-style instruction. An instruction arrives as a 3-bit addressing-mode code, a 12-bit address/immediate field and a register select. Depending on the mode, the unit makes zero, one or two memory reads and then reports the operand on a one-cycle completion strobe.

The register file sits outside the unit. The unit drives the register select onto `rf_sel` and samples `rf_data`, which carries the low 12 bits of that register, in the cycle it accepts an instruction. It samples the stack pointer in the same cycle. Memory is reached through a request/valid read port. The unit keeps its request and address steady until the read-valid pulse arrives, so reads of any latency are handled.

Mode codes are 0 immediate, 1 direct, 2 indirect, 3 indexed, 4 register indirect and 5 stack. Codes 6 and 7 complete at once with an error flag. All address arithmetic wraps modulo 4096.

Top module: `opfetch_unit`

## Requirements
- R1: Mode 0 (immediate): the operand is the 12-bit field zero-extended to 16 bits. The completion strobe rises in the cycle after acceptance and no memory read is made.
- R2: Mode 1 (direct): exactly one read is made, at the field value, and the operand is the data returned.
- R3: Mode 2 (indirect): two reads are made. The first is at the field value. The second is at the low 12 bits of the first read's data, and its data is the operand.
- R4: Mode 3 (indexed): one read is made at (register low bits + field) modulo 4096. For example, register 800 with field 800 reads location 1600.
- R5: Mode 4 (register indirect): one read is made at the selected register's low 12 bits.
- R6: Mode 5 (stack): one read is made at the stack pointer sampled when the instruction was accepted.
- R7: Mode codes 6 and 7: the unit completes in the cycle after acceptance with the error flag set and an operand of 0, and makes no read. The error flag is never high without the completion strobe.
- R8: Once raised, the memory request stays high with a stable address until read-valid is seen.
- R9: Each accepted instruction produces exactly one single-cycle completion strobe. `instr_ready` is low while reads are outstanding, and an instruction offered then is ignored.
- R10: After reset, `instr_ready` is 1 and both the completion strobe and the memory request are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction offered |
| instr_mode | input | 3 | Addressing-mode code |
| instr_field | input | 12 | Address, offset or immediate field |
| instr_reg | input | 3 | Register select for modes 3 and 4 |
| instr_ready | output | 1 | Unit idle; an offered instruction is accepted |
| rf_sel | output | 3 | Register file read select |
| rf_data | input | 12 | Low bits of the selected register |
| stack_ptr | input | 12 | Stack pointer value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 12 | Memory read address |
| mem_rvalid | input | 1 | Read data valid (one-cycle pulse) |
| mem_rdata | input | 16 | Read data |
| opnd_done | output | 1 | Operand complete strobe |
| opnd_err | output | 1 | Illegal mode, valid with the strobe |
| opnd_value | output | 16 | Resolved operand |

## Verification
The assertions assume that the memory raises read-valid only while a request is pending, as a single-cycle pulse, and that `rf_data` and `stack_ptr` are valid in the cycle an instruction is accepted. The bench memory model answers only an active request, with a random latency of one to four cycles, and drops read-valid for at least one cycle after each pulse. The bench holds the register contents and the stack pointer steady from the offer until completion. Instructions offered while the unit is busy test that they are ignored, and they never break these input rules.

// File: rtl/opf_pkg.sv
package opf_pkg;
  typedef enum logic [2:0] {
    AM_IMM  = 3'd0,
    AM_DIR  = 3'd1,
    AM_IND  = 3'd2,
    AM_IDX  = 3'd3,
    AM_RIND = 3'd4,
    AM_STK  = 3'd5
  } amode_t;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_FIRST  = 2'd1,
    SQ_SECOND = 2'd2
  } sq_state_t;
endpackage

// File: rtl/opf_addr_gen.sv
module opf_addr_gen
  import opf_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] field,
  input  logic [ADDR_W-1:0] reg_val,
  input  logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] first_addr,
  output logic              needs_mem,
  output logic              chain,
  output logic              illegal
);
  // the sum keeps ADDR_W bits, so the carry out is dropped (modulo wrap)
  logic [ADDR_W-1:0] idx_sum;
  assign idx_sum = reg_val + field;

  always_comb begin
    first_addr = field;
    needs_mem  = 1'b1;
    chain      = 1'b0;
    illegal    = 1'b0;
    case (amode_t'(mode))
      AM_IMM:  needs_mem  = 1'b0;
      AM_DIR:  first_addr = field;
      AM_IND:  chain      = 1'b1;
      AM_IDX:  first_addr = idx_sum;
      AM_RIND: first_addr = reg_val;
      AM_STK:  first_addr = sp;
      default: begin
        needs_mem = 1'b0;
        illegal   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/opf_seq.sv
module opf_seq
  import opf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              ready,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic              needs_mem,
  input  logic              chain,
  input  logic              illegal,
  input  logic [DATA_W-1:0] imm_val,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] operand
);
  sq_state_t         st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              chain_q, chain_d;
  logic [DATA_W-1:0] op_q, op_d;
  logic              done_q, done_d, err_q, err_d;
  logic              addr_en, op_en;
  logic              accept;

  assign ready   = (st_q == SQ_IDLE);
  assign accept  = ready && instr_valid;
  assign mem_req = (st_q != SQ_IDLE);
  assign mem_addr = addr_q;
  assign done    = done_q;
  assign err     = err_q;
  assign operand = op_q;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    chain_d = chain_q;
    op_d    = op_q;
    addr_en = 1'b0;
    op_en   = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (instr_valid) begin
          if (illegal) begin
            done_d = 1'b1;
            err_d  = 1'b1;
            op_d   = '0;
            op_en  = 1'b1;
          end else if (!needs_mem) begin
            done_d = 1'b1;
            op_d   = imm_val;
            op_en  = 1'b1;
          end else begin
            st_d    = SQ_FIRST;
            addr_d  = first_addr;
            chain_d = chain;
            addr_en = 1'b1;
          end
        end
      end
      SQ_FIRST: begin
        if (mem_rvalid) begin
          if (chain_q) begin
            st_d    = SQ_SECOND;
            addr_d  = mem_rdata[ADDR_W-1:0];
            addr_en = 1'b1;
          end else begin
            st_d   = SQ_IDLE;
            op_d   = mem_rdata;
            op_en  = 1'b1;
            done_d = 1'b1;
          end
        end
      end
      SQ_SECOND: begin
        if (mem_rvalid) begin
          st_d   = SQ_IDLE;
          op_d   = mem_rdata;
          op_en  = 1'b1;
          done_d = 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      addr_q  <= '0;
      chain_q <= 1'b0;
      op_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (addr_en) begin
        addr_q  <= addr_d;
        chain_q <= chain_d;
      end
      if (op_en) op_q <= op_d;
    end
  end

  // R1
  imm_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !needs_mem && !illegal) |=> (done && !err && operand == $past(imm_val)));

  // R7
  illegal_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && illegal) |=> (done && err && operand == '0));

  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R3
  chain_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_FIRST && chain_q && mem_rvalid) |=>
      (mem_req && mem_addr == $past(mem_rdata[ADDR_W-1:0])));

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !ready);
endmodule

// File: rtl/opfetch_unit.sv
module opfetch_unit #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  localparam int RSEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [2:0]        instr_mode,
  input  logic [ADDR_W-1:0] instr_field,
  input  logic [RSEL_W-1:0] instr_reg,
  output logic              instr_ready,
  output logic [RSEL_W-1:0] rf_sel,
  input  logic [ADDR_W-1:0] rf_data,
  input  logic [ADDR_W-1:0] stack_ptr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              opnd_done,
  output logic              opnd_err,
  output logic [DATA_W-1:0] opnd_value
);
  localparam int PAD_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] first_addr;
  logic              needs_mem, chain, illegal;
  logic [DATA_W-1:0] imm_val;

  assign rf_sel = instr_reg;

  generate
    if (PAD_W > 0) begin : g_pad
      assign imm_val = {{PAD_W{1'b0}}, instr_field};
    end else begin : g_trunc
      assign imm_val = instr_field[DATA_W-1:0];
    end
  endgenerate

  opf_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .mode       (instr_mode),
    .field      (instr_field),
    .reg_val    (rf_data),
    .sp         (stack_ptr),
    .first_addr (first_addr),
    .needs_mem  (needs_mem),
    .chain      (chain),
    .illegal    (illegal)
  );

  opf_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .ready       (instr_ready),
    .first_addr  (first_addr),
    .needs_mem   (needs_mem),
    .chain       (chain),
    .illegal     (illegal),
    .imm_val     (imm_val),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .done        (opnd_done),
    .err         (opnd_err),
    .operand     (opnd_value)
  );
endmodule

// File: tb/opfetch_unit_test.sv
`timescale 1ns/1ps
module opfetch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [2:0]  instr_mode = 3'd0;
  logic [11:0] instr_field = 12'd0;
  logic [2:0]  instr_reg = 3'd0;
  logic        instr_ready;
  logic [2:0]  rf_sel;
  logic [11:0] rf_data;
  logic [11:0] stack_ptr = 12'd0;
  logic        mem_req;
  logic [11:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = 16'd0;
  logic        opnd_done, opnd_err;
  logic [15:0] opnd_value;

  logic [11:0] regs [0:7];
  int checks = 0, fails = 0;
  int rd_cnt = 0, done_cnt = 0, lat = 0, cycles = 0;
  logic [11:0] rd_log [0:3];
  logic [15:0] last_op;
  logic        last_err;

  always #2 clk = ~clk;
  assign rf_data = regs[rf_sel];

  opfetch_unit uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_mode(instr_mode),
    .instr_field(instr_field), .instr_reg(instr_reg), .instr_ready(instr_ready),
    .rf_sel(rf_sel), .rf_data(rf_data), .stack_ptr(stack_ptr), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .opnd_done(opnd_done), .opnd_err(opnd_err), .opnd_value(opnd_value)
  );

  function automatic logic [15:0] memf(input logic [11:0] a);
    logic [31:0] t;
    t = ({20'd0, a} * 32'd2654) ^ 32'h3C5A;
    return t[15:0];
  endfunction

  function automatic logic [11:0] exp_addr(input logic [2:0] m, input logic [11:0] f,
                                           input logic [11:0] r, input logic [11:0] s);
    logic [12:0] sum;
    sum = {1'b0, r} + {1'b0, f};
    case (m)
      3'd3: return sum[11:0];
      3'd4: return r;
      3'd5: return s;
      default: return f;
    endcase
  endfunction

  function automatic logic [15:0] exp_op(input logic [2:0] m, input logic [11:0] f,
                                         input logic [11:0] r, input logic [11:0] s);
    logic [15:0] p;
    if (m == 3'd0) return {4'd0, f};
    if (m >= 3'd6) return 16'd0;
    if (m == 3'd2) begin
      p = memf(f);
      return memf(p[11:0]);
    end
    return memf(exp_addr(m, f, r, s));
  endfunction

  // memory model: answers only a pending request, latency 1..4, one-cycle pulse
  always @(negedge clk) begin
    cycles = cycles + 1;
    if (!rst_n) begin
      mem_rvalid = 1'b0;
    end else if (mem_rvalid) begin
      mem_rvalid = 1'b0;
    end else if (mem_req) begin
      if (lat == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata = memf(mem_addr);
        rd_log[rd_cnt % 4] = mem_addr;
        rd_cnt = rd_cnt + 1;
        lat = $urandom % 4;
      end else begin
        lat = lat - 1;
      end
    end
    if (opnd_done) begin
      done_cnt = done_cnt + 1;
      last_op = opnd_value;
      last_err = opnd_err;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run(input logic [2:0] m, input logic [11:0] f, input logic [2:0] rs,
                     input logic [11:0] s, input bit poke);
    int rd_base, done_base, waited, nreads;
    logic [11:0] rv;
    string rq;
    rq = req_of(m);
    rv = regs[rs];
    @(negedge clk); #1;
    instr_mode = m; instr_field = f; instr_reg = rs; stack_ptr = s;
    instr_valid = 1'b1;
    rd_base = rd_cnt; done_base = done_cnt;
    @(negedge clk); #1;
    instr_valid = 1'b0;
    waited = 1;
    if (poke && !instr_ready) begin
      // R9: offered while busy, must be ignored
      instr_mode = 3'd0; instr_field = 12'hABC;
      instr_valid = 1'b1;
      @(negedge clk); #1;
      instr_valid = 1'b0;
      waited++;
    end
    while (done_cnt == done_base && waited < 100) begin
      @(negedge clk); #1;
      waited++;
    end
    chk(done_cnt != done_base, "R9 done timeout", done_cnt - done_base, 1);
    @(negedge clk); #1;
    @(negedge clk); #1;
    chk(done_cnt - done_base == 1, "R9 one strobe", done_cnt - done_base, 1);
    chk(last_op == exp_op(m, f, rv, s), rq, last_op, exp_op(m, f, rv, s));
    chk(last_err == (m >= 3'd6), "R7 err flag", last_err, (m >= 3'd6));
    nreads = rd_cnt - rd_base;
    if (m == 3'd0 || m >= 3'd6) begin
      chk(nreads == 0, rq, nreads, 0);
      chk(waited == 1, rq, waited, 1);
    end else if (m == 3'd2) begin
      logic [15:0] p;
      p = memf(f);
      chk(nreads == 2, "R3 read count", nreads, 2);
      chk(rd_log[rd_base % 4] == f, "R3 first addr", rd_log[rd_base % 4], f);
      chk(rd_log[(rd_base + 1) % 4] == p[11:0], "R3 second addr",
          rd_log[(rd_base + 1) % 4], p[11:0]);
    end else begin
      chk(nreads == 1, rq, nreads, 1);
      chk(rd_log[rd_base % 4] == exp_addr(m, f, rv, s), rq,
          rd_log[rd_base % 4], exp_addr(m, f, rv, s));
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) regs[i] = 12'(i * 100);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(instr_ready == 1'b1, "R10 ready", instr_ready, 1);
    chk(opnd_done == 1'b0, "R10 done", opnd_done, 0);
    chk(mem_req == 1'b0, "R10 req", mem_req, 0);
    rst_n = 1'b1;
    // directed corners
    regs[1] = 12'd800;
    run(3'd1, 12'd800, 3'd1, 12'd5, 1'b0);    // R2 direct at 800
    run(3'd2, 12'd800, 3'd1, 12'd5, 1'b0);    // R3 pointer at 800
    run(3'd3, 12'd800, 3'd1, 12'd5, 1'b0);    // R4 reads 1600
    regs[2] = 12'd200;
    run(3'd3, 12'd4000, 3'd2, 12'd5, 1'b1);   // R4 wrap to 104
    run(3'd4, 12'd7, 3'd2, 12'd5, 1'b1);      // R5
    run(3'd5, 12'd7, 3'd2, 12'hFFF, 1'b1);    // R6
    run(3'd0, 12'hFFF, 3'd0, 12'd0, 1'b0);    // R1 max field
    run(3'd6, 12'd1, 3'd0, 12'd0, 1'b0);      // R7
    run(3'd7, 12'd1, 3'd0, 12'd0, 1'b0);      // R7
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < 8; i++) regs[i] = 12'($urandom);
      run(3'($urandom % 8), 12'($urandom), 3'($urandom), 12'($urandom), 1'($urandom));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule